// File: doc/BRIEF.md
# Per-Core Interrupt Doorbell and Mailbox Register Bank

This block holds the inter-processor interrupt state of one processor core. Software on any core, or routing logic outside the block, posts interrupt bits into a 32-bit pending word. A 32-bit enable word selects which pending bits may raise the interrupt line. The pending word itself is read-only. It changes only through a write-one-to-set port, a write-one-to-clear port and an external post input. Eight 32-bit mailbox words carry message data alongside the doorbell.

The interrupt line is a registered flag with asymmetric rules. It is raised only by a set event whose resulting pending bits overlap the enable word. It is dropped only by a clear write that leaves the pending word empty while the enable word is nonzero. It is therefore not a live OR of pending and enable. Software can use this to keep a line asserted across enable changes. The register bus is a simple strobe interface with an 8-bit byte offset and 32-bit little-endian words.

Top module: `ipi_core_regs`

## Requirements
- R1: The pending word (offset 0x00) is read-only. A bus write to 0x00 leaves the pending word and the interrupt line unchanged.
- R2: A read of the set port (0x08) or of the clear port (0x0C) returns zero.
- R3: A write to 0x08 ORs the data into the pending word. The interrupt line goes to 1 if the new pending word ANDed with enable is nonzero; otherwise it keeps its value.
- R4: A write to 0x0C clears the written bits from the pending word. The interrupt line goes to 0 only if the pending word becomes zero and the enable word is nonzero; otherwise it keeps its value.
- R5: A write to 0x04 replaces the enable word, which reads back at 0x04. The write does not change the interrupt line.
- R6: Offsets 0x20 to 0x3F hold eight mailbox words. Word number (offset - 0x20) >> 2 is selected, and offset bits [1:0] are ignored for every register.
- R7: A nonzero post input ORs its bits into the pending word in that cycle and raises the interrupt line under the same rule as R3.
- R8: If a set write and a post arrive in the same cycle, both are ORed in. If a clear write and a post arrive together, the clear is applied first and the posted bits remain set.
- R9: Reads of unmapped offsets (0x10 to 0x1F, 0x40 and above) return zero. Writes to those offsets change no register.
- R10: Read data appears on the read-data output in the cycle after the read strobe is sampled. At all other times that output is zero.
- R11: After reset, the pending word, the enable word, every mailbox word and the interrupt line are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| post_bits_i | input | 32 | Interrupt bits posted by external logic, ORed in when nonzero |
| irq_o | output | 1 | Registered interrupt line to the core |

## Verification
Every write and post takes effect at the clock edge that samples it. The pending word, enable word, mailbox words and interrupt line therefore show their new values one edge after the stimulus. Read data takes one more register stage and is valid exactly one edge after the read strobe. The bench drives stimulus on falling edges and samples the interrupt line at the falling edge right after the edge that takes the write. A monitor compares each read against a queue of expected words, popping one entry at the falling edge that follows an edge which sampled a read strobe.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_ENAB,
    SEL_SET,
    SEL_CLR,
    SEL_MBOX
  } reg_sel_e;

  localparam logic [7:0] OFS_STAT  = 8'h00;
  localparam logic [7:0] OFS_ENAB  = 8'h04;
  localparam logic [7:0] OFS_SET   = 8'h08;
  localparam logic [7:0] OFS_CLR   = 8'h0C;
  localparam logic [7:0] OFS_MBOX  = 8'h20;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned MBOX_WORDS = 8,
  localparam int unsigned WA_W      = ADDR_W - 2,
  localparam int unsigned IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [WA_W-1:0]  word_addr_i,
  output reg_sel_e         sel_o,
  output logic [IDX_W-1:0] mbox_idx_o
);
  logic [WA_W-1:0] mbox_off;

  always_comb begin
    mbox_off   = word_addr_i - WA_W'(OFS_MBOX >> 2);
    mbox_idx_o = mbox_off[IDX_W-1:0];
    if (word_addr_i == WA_W'(OFS_STAT >> 2))      sel_o = SEL_STAT;
    else if (word_addr_i == WA_W'(OFS_ENAB >> 2)) sel_o = SEL_ENAB;
    else if (word_addr_i == WA_W'(OFS_SET >> 2))  sel_o = SEL_SET;
    else if (word_addr_i == WA_W'(OFS_CLR >> 2))  sel_o = SEL_CLR;
    else if (mbox_off < WA_W'(MBOX_WORDS))        sel_o = SEL_MBOX;
    else                                          sel_o = SEL_NONE;
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 8,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            word_q[g] <= '0;
      else if (wr_i && idx_i == IDX_W'(g))    word_q[g] <= wdata_i;
    end
  end

  assign rdata_o = word_q[idx_i];

  // R6
  mbox_wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o == $past(wdata_i) || idx_i != $past(idx_i));
endmodule

// File: rtl/ipi_irq_ctrl.sv
module ipi_irq_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wr_i,
  input  logic              clr_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] post_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, status_d, enable_q, set_bits, clr_bits;
  logic              irq_q, irq_d, raise, lower;

  always_comb begin
    set_bits = (set_wr_i ? wdata_i : '0) | post_i;
    clr_bits = clr_wr_i ? wdata_i : '0;
    // clear before post so posted bits survive a same-cycle clear
    status_d = (status_q & ~clr_bits) | set_bits;
    raise    = (|set_bits) && (|(status_d & enable_q));
    lower    = clr_wr_i && (status_d == '0) && (|enable_q);
    irq_d    = raise ? 1'b1 : (lower ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
      if (en_wr_i) enable_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  // R3
  irq_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(set_wr_i || (|post_i)));
  // R4
  irq_fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(clr_wr_i) && status_q == '0);
  // R5
  en_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !set_wr_i && !clr_wr_i && post_i == '0) |=> $stable(irq_q));
  // R1
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_wr_i && !clr_wr_i && post_i == '0) |=> $stable(status_q));
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MBOX_WORDS = 8,
  localparam int unsigned IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] post_bits_i,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [IDX_W-1:0]  mbox_idx;
  logic [DATA_W-1:0] status, enable, mbox_rdata, rd_mux, rdata_q;
  logic [1:0]        unused_byte_lanes;

  assign unused_byte_lanes = bus_addr_i[1:0];

  ipi_addr_decode #(
    .ADDR_W     (ADDR_W),
    .MBOX_WORDS (MBOX_WORDS)
  ) u_decode (
    .word_addr_i (bus_addr_i[ADDR_W-1:2]),
    .sel_o       (sel),
    .mbox_idx_o  (mbox_idx)
  );

  ipi_irq_ctrl #(
    .DATA_W (DATA_W)
  ) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_wr_i (bus_wr_i && sel == SEL_SET),
    .clr_wr_i (bus_wr_i && sel == SEL_CLR),
    .en_wr_i  (bus_wr_i && sel == SEL_ENAB),
    .wdata_i  (bus_wdata_i),
    .post_i   (post_bits_i),
    .status_o (status),
    .enable_o (enable),
    .irq_o    (irq_o)
  );

  ipi_mailbox #(
    .DATA_W (DATA_W),
    .WORDS  (MBOX_WORDS)
  ) u_mbox (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i && sel == SEL_MBOX),
    .idx_i   (mbox_idx),
    .wdata_i (bus_wdata_i),
    .rdata_o (mbox_rdata)
  );

  always_comb begin
    case (sel)
      SEL_STAT: rd_mux = status;
      SEL_ENAB: rd_mux = enable;
      SEL_MBOX: rd_mux = mbox_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
    else               rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;

  // R2
  set_clr_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && (sel == SEL_SET || sel == SEL_CLR)) |=> bus_rdata_o == '0);
  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == '0);
endmodule

// File: tb/ipi_core_regs_tb_top.sv
module ipi_core_regs_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] post_bits = '0;
  logic        irq;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_core_regs dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (bus_addr),
    .bus_wr_i    (bus_wr),
    .bus_rd_i    (bus_rd),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .post_bits_i (post_bits),
    .irq_o       (irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: one expected word per sampled read strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hxxxx_xxxx, "R10 unexpected read data");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic drive(input logic w, input logic r, input logic [7:0] a,
                       input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; post_bits = p;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; post_bits = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, 1'b0, a, d, '0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    drive(1'b0, 1'b1, a, '0, '0);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    check({31'b0, irq}, {31'b0, exp}, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk_irq(1'b0, "R11 irq after reset");
    rd(8'h00, 32'h0, "R11 status reset");
    rd(8'h04, 32'h0, "R11 enable reset");
    rd(8'h3C, 32'h0, "R11 mailbox reset");

    wr(8'h04, 32'h0000_00F0);
    chk_irq(1'b0, "R5 enable write no irq");
    rd(8'h04, 32'h0000_00F0, "R5 enable readback");

    wr(8'h08, 32'h1);
    chk_irq(1'b0, "R3 set masked bit");
    rd(8'h00, 32'h1, "R3 status after set");
    wr(8'h08, 32'h10);
    chk_irq(1'b1, "R3 set enabled bit raises");
    rd(8'h00, 32'h11, "R3 status accumulates");

    rd(8'h08, 32'h0, "R2 set port reads zero");
    rd(8'h0C, 32'h0, "R2 clear port reads zero");

    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00, 32'h11, "R1 status write ignored");
    chk_irq(1'b1, "R1 irq after status write");

    wr(8'h04, 32'h0);
    chk_irq(1'b1, "R5 enable clear keeps irq");
    wr(8'h0C, 32'h1);
    chk_irq(1'b1, "R4 partial clear keeps irq");
    rd(8'h00, 32'h10, "R4 status after partial clear");
    wr(8'h0C, 32'h10);
    chk_irq(1'b1, "R4 empty with zero enable keeps irq");
    rd(8'h00, 32'h0, "R4 status emptied");

    wr(8'h04, 32'h0000_00F0);
    wr(8'h08, 32'h1);
    chk_irq(1'b1, "R3 masked set leaves irq");
    wr(8'h0C, 32'h1);
    chk_irq(1'b0, "R4 empty with enable lowers irq");

    drive(1'b0, 1'b0, 8'h00, '0, 32'h20);
    chk_irq(1'b1, "R7 post raises irq");
    rd(8'h00, 32'h20, "R7 post sets status");
    wr(8'h0C, 32'h20);
    chk_irq(1'b0, "R4 clear after post");

    drive(1'b1, 1'b0, 8'h08, 32'h100, 32'h200);
    rd(8'h00, 32'h300, "R8 set and post merge");
    chk_irq(1'b0, "R3 merged bits masked");
    drive(1'b1, 1'b0, 8'h0C, 32'h300, 32'h40);
    rd(8'h00, 32'h40, "R8 clear then post");
    chk_irq(1'b1, "R8 post beside clear raises");

    for (int i = 0; i < 8; i++) wr(8'(8'h20 + 4 * i), 32'hA500_0000 | (i * 32'h11));
    for (int i = 0; i < 8; i++) rd(8'(8'h20 + 4 * i), 32'hA500_0000 | (i * 32'h11), "R6 mailbox word");
    wr(8'h2E, 32'hDEAD_BEEF);
    rd(8'h2C, 32'hDEAD_BEEF, "R6 byte lanes ignored on write");
    rd(8'h3D, 32'hA500_0077, "R6 byte lanes ignored on read");

    wr(8'h40, 32'h123);
    wr(8'h10, 32'hFFFF);
    wr(8'hFC, 32'h1);
    rd(8'h40, 32'h0, "R9 unmapped 0x40 reads zero");
    rd(8'h44, 32'h0, "R9 unmapped 0x44 reads zero");
    rd(8'h10, 32'h0, "R9 unmapped 0x10 reads zero");
    rd(8'hFC, 32'h0, "R9 unmapped 0xFC reads zero");
    rd(8'h00, 32'h40, "R9 status untouched");
    rd(8'h04, 32'h0000_00F0, "R9 enable untouched");
    rd(8'h20, 32'hA500_0000, "R9 mailbox untouched");

    @(negedge clk);
    check(bus_rdata, 32'h0, "R10 rdata zero when idle");

    repeat (2) @(negedge clk);
    check(32'(exp_q.size()), 32'h0, "R10 all reads returned");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule